// File: doc/BRIEF.md
# Card Command Line Sequence Generator

This block drives the command wire of an SD/MMC host controller while the wire carries something other than a framed command. Three fixed patterns are produced. The first is a power-up stream that holds the wire high so the card can finish its start-up. The second is a boot hold that pulls the wire low until software lets it go. The third is the CE-ATA token that disables command completion signalling: a long low run followed by one high bit. Command framing, CRC generation and response capture are handled by other logic and are not part of this block.

Control comes from register-style levels: an init request, a boot force, CE-ATA mode, host-response mode and open-drain mode. A one-cycle trigger stands for a write to the command register, and it carries a 32-bit argument. Every change on the wire is paced by a card-clock enable tick. Between sequences the driver is off, so the external pull-up holds the wire high. A busy flag covers each sequence. A one-cycle done pulse marks the end of the init stream and of the token. A one-cycle abort pulse marks the release of a boot hold.

Top module: `cmdseq_gen`

## Requirements
- R1: When idle with init_req high and armed, the next tick starts an init stream. The wire is driven (cmd_oe=1) at level 1 for exactly 80 ticks, then released. A done pulse is raised in the cycle of release.
- R2: An init stream starts only once per assertion of init_req. init_req must be seen low before another stream can start. Holding init_req high after a stream leaves the wire released.
- R3: A trigger accepted while idle, with boot_force=1 at the next tick, drives the wire to 0 (cmd_oe=1) from that tick on.
- R4: The boot hold ends at the first tick where boot_force is 0. The wire is then released and abort pulses high for one cycle.
- R5: A trigger accepted while idle, with ceata_mode=1, host_resp=1 and an argument of 0x00000000, and with boot_force=0, starts the completion-disable token. The token is 47 ticks at level 0, then 1 tick at level 1, then release with a done pulse.
- R6: cmd_od is 1 throughout the token exactly when od_mode is 1. In that case the high bit is not driven: cmd_oe=0 and cmd_o=1 during that tick.
- R7: cmd_o, cmd_oe and busy change only on clock edges where clk_en is 1.
- R8: When idle, and after reset, the outputs are cmd_oe=0, cmd_od=0, cmd_o=1, busy=0, done=0 and abort=0.
- R9: busy is 1 exactly while a sequence owns the wire. Triggers and init requests that arrive while busy are ignored.
- R10: An accepted trigger with boot_force=0 that does not meet the token condition of R5 starts no sequence. This covers a non-zero argument, or either mode bit clear.
- R11: A pending trigger takes priority over a simultaneous init request. The init stream then starts at the first idle tick after the triggered sequence ends.
- R12: done and abort are never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Card-clock enable tick |
| init_req | input | 1 | Request for the power-up high stream |
| boot_force | input | 1 | Hold the wire low for boot; clearing releases it |
| ceata_mode | input | 1 | CE-ATA command mode |
| host_resp | input | 1 | Host-generated response mode |
| od_mode | input | 1 | Open-drain drive for host-generated patterns |
| cmd_trig | input | 1 | One-cycle command-register write strobe |
| cmd_arg | input | 32 | Command argument captured with the trigger |
| cmd_o | output | 1 | Command wire output level |
| cmd_oe | output | 1 | Command wire output enable |
| cmd_od | output | 1 | Open-drain drive indication |
| busy | output | 1 | A sequence owns the wire |
| done | output | 1 | One-cycle end pulse for the init stream or the token |
| abort | output | 1 | One-cycle pulse on boot release; aborts pending data |

## Verification
The hardest situation to reach from the ports is a collision between a pending trigger and an init request. The trigger is only captured on a clock edge, while the choice between the two is made on a tick. To reach this case, the stimulus raises the trigger and then raises init_req one cycle later, while boot_force is held. This puts a captured trigger and an armed request in front of the same tick. Both the boot hold and the follow-on stream are then checked for order and length. Strobes that arrive during an init stream and during a boot hold check that busy sequences ignore them. The scoreboard rejects any segment it did not expect.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE = 3'd0,
        SEQ_INIT = 3'd1,
        SEQ_BOOT = 3'd2,
        SEQ_TOKL = 3'd3,
        SEQ_TOKH = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic drive;
        logic level;
        logic odrain;
    } line_t;

    localparam line_t LINE_RELEASED = '{drive: 1'b0, level: 1'b1, odrain: 1'b0};

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic is_token(input seq_state_e st);
        return (st == SEQ_TOKL) || (st == SEQ_TOKH);
    endfunction

    function automatic line_t line_for(input seq_state_e st, input logic od);
        line_t l;
        l = LINE_RELEASED;
        case (st)
            SEQ_INIT: begin
                l.drive = 1'b1;
                l.level = 1'b1;
            end
            SEQ_BOOT: begin
                l.drive = 1'b1;
                l.level = 1'b0;
            end
            SEQ_TOKL: begin
                l.drive  = 1'b1;
                l.level  = 1'b0;
                l.odrain = od;
            end
            SEQ_TOKH: begin
                l.drive  = ~od;
                l.level  = 1'b1;
                l.odrain = od;
            end
            default: l = LINE_RELEASED;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/cmdseq_trigcap.sv
module cmdseq_trigcap #(
    parameter int ARG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic [ARG_W-1:0] arg,
    input  logic             idle,
    input  logic             consume,
    output logic             pend,
    output logic             arg_zero
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            arg_zero <= 1'b0;
        end else if (trig && idle) begin
            pend     <= 1'b1;
            arg_zero <= (arg == '0);
        end else if (consume) begin
            pend     <= 1'b0;
        end
    end

endmodule

// File: rtl/cmdseq_tickcnt.sv
module cmdseq_tickcnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/cmdseq_ctrl.sv
module cmdseq_ctrl
    import cmdseq_pkg::*;
#(
    parameter int CNT_W    = 7,
    parameter int INIT_LEN = 80,
    parameter int TOKL_LEN = 47
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             init_req,
    input  logic             boot_force,
    input  logic             ceata_mode,
    input  logic             host_resp,
    input  logic             pend,
    input  logic             arg_zero,
    input  logic             cnt_zero,
    output seq_state_e       state,
    output logic             cnt_load,
    output logic [CNT_W-1:0] cnt_val,
    output logic             cnt_dec,
    output logic             consume,
    output logic             done,
    output logic             abort
);

    localparam logic [CNT_W-1:0] INIT_LOAD = CNT_W'(INIT_LEN - 1);
    localparam logic [CNT_W-1:0] TOKL_LOAD = CNT_W'(TOKL_LEN - 1);

    seq_state_e state_n;
    logic       armed_q;
    logic       start_init;
    logic       fin_done;
    logic       fin_abort;
    logic       token_ok;

    assign token_ok = ceata_mode && host_resp && arg_zero;

    always_comb begin
        state_n    = state;
        cnt_load   = 1'b0;
        cnt_val    = '0;
        cnt_dec    = 1'b0;
        consume    = 1'b0;
        start_init = 1'b0;
        fin_done   = 1'b0;
        fin_abort  = 1'b0;
        if (tick) begin
            case (state)
                SEQ_IDLE: begin
                    if (pend) begin
                        consume = 1'b1;
                        if (boot_force) begin
                            state_n = SEQ_BOOT;
                        end else if (token_ok) begin
                            state_n  = SEQ_TOKL;
                            cnt_load = 1'b1;
                            cnt_val  = TOKL_LOAD;
                        end
                    end else if (init_req && armed_q) begin
                        state_n    = SEQ_INIT;
                        cnt_load   = 1'b1;
                        cnt_val    = INIT_LOAD;
                        start_init = 1'b1;
                    end
                end
                SEQ_INIT: begin
                    if (cnt_zero) begin
                        state_n  = SEQ_IDLE;
                        fin_done = 1'b1;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
                SEQ_BOOT: begin
                    if (!boot_force) begin
                        state_n   = SEQ_IDLE;
                        fin_abort = 1'b1;
                    end
                end
                SEQ_TOKL: begin
                    if (cnt_zero) begin
                        state_n = SEQ_TOKH;
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
                SEQ_TOKH: begin
                    state_n  = SEQ_IDLE;
                    fin_done = 1'b1;
                end
                default: state_n = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            armed_q <= 1'b1;
            done    <= 1'b0;
            abort   <= 1'b0;
        end else begin
            state <= state_n;
            done  <= fin_done;
            abort <= fin_abort;
            if (start_init) begin
                armed_q <= 1'b0;
            end else if (!init_req) begin
                armed_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cmdseq_linedrv.sv
module cmdseq_linedrv
    import cmdseq_pkg::*;
(
    input  seq_state_e state,
    input  logic       od_mode,
    output logic       cmd_o,
    output logic       cmd_oe,
    output logic       cmd_od,
    output logic       busy
);

    line_t line;

    always_comb begin
        line   = line_for(state, od_mode);
        cmd_o  = line.level;
        cmd_oe = line.drive;
        cmd_od = line.odrain;
        busy   = (state != SEQ_IDLE);
    end

endmodule

// File: rtl/cmdseq_gen.sv
module cmdseq_gen
    import cmdseq_pkg::*;
#(
    parameter int ARG_W    = 32,
    parameter int INIT_LEN = 80,
    parameter int TOKL_LEN = 47
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic             init_req,
    input  logic             boot_force,
    input  logic             ceata_mode,
    input  logic             host_resp,
    input  logic             od_mode,
    input  logic             cmd_trig,
    input  logic [ARG_W-1:0] cmd_arg,
    output logic             cmd_o,
    output logic             cmd_oe,
    output logic             cmd_od,
    output logic             busy,
    output logic             done,
    output logic             abort
);

    localparam int MAX_LEN = int'(max_u(INIT_LEN, TOKL_LEN));
    localparam int CNT_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;

    seq_state_e       state;
    logic             pend;
    logic             arg_zero;
    logic             consume;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_dec;
    logic             cnt_zero;

    cmdseq_trigcap #(.ARG_W(ARG_W)) u_trig (
        .clk      (clk),
        .rst      (rst),
        .trig     (cmd_trig),
        .arg      (cmd_arg),
        .idle     (state == SEQ_IDLE),
        .consume  (consume),
        .pend     (pend),
        .arg_zero (arg_zero)
    );

    cmdseq_tickcnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    cmdseq_ctrl #(
        .CNT_W    (CNT_W),
        .INIT_LEN (INIT_LEN),
        .TOKL_LEN (TOKL_LEN)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .tick       (clk_en),
        .init_req   (init_req),
        .boot_force (boot_force),
        .ceata_mode (ceata_mode),
        .host_resp  (host_resp),
        .pend       (pend),
        .arg_zero   (arg_zero),
        .cnt_zero   (cnt_zero),
        .state      (state),
        .cnt_load   (cnt_load),
        .cnt_val    (cnt_val),
        .cnt_dec    (cnt_dec),
        .consume    (consume),
        .done       (done),
        .abort      (abort)
    );

    cmdseq_linedrv u_drv (
        .state   (state),
        .od_mode (od_mode),
        .cmd_o   (cmd_o),
        .cmd_oe  (cmd_oe),
        .cmd_od  (cmd_od),
        .busy    (busy)
    );

endmodule

// File: rtl/cmdseq_gen_chk.sv
module cmdseq_gen_chk (
    input logic clk,
    input logic rst,
    input logic clk_en,
    input logic boot_force,
    input logic cmd_o,
    input logic cmd_oe,
    input logic cmd_od,
    input logic busy,
    input logic done,
    input logic abort
);

    a_r7_tick_paced: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(busy) && $stable(cmd_o)));

    a_r8_idle_released: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!cmd_oe && !cmd_od && cmd_o));

    a_r4_abort_on_release: assert property (@(posedge clk) disable iff (rst)
        $rose(abort) |-> (!busy && !$past(boot_force)));

    a_r6_od_never_drives_high: assert property (@(posedge clk) disable iff (rst)
        (cmd_od && cmd_oe) |-> !cmd_o);

    a_r12_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r12_abort_single: assert property (@(posedge clk) disable iff (rst)
        abort |=> !abort);

    a_r1_done_at_release: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

bind cmdseq_gen cmdseq_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_en     (clk_en),
    .boot_force (boot_force),
    .cmd_o      (cmd_o),
    .cmd_oe     (cmd_oe),
    .cmd_od     (cmd_od),
    .busy       (busy),
    .done       (done),
    .abort      (abort)
);

// File: tb/cmdseq_gen_tb.sv
module cmdseq_gen_tb;

    localparam int K_SEG   = 0;
    localparam int K_DONE  = 1;
    localparam int K_ABORT = 2;

    typedef struct {
        int    kind;
        bit    oe;
        bit    lvl;
        bit    od;
        int    ticks;
        string req;
    } item_t;

    item_t exp_q[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R8";

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b0;
    logic        init_req = 1'b0;
    logic        boot_force = 1'b0;
    logic        ceata_mode = 1'b0;
    logic        host_resp = 1'b0;
    logic        od_mode = 1'b0;
    logic        cmd_trig = 1'b0;
    logic [31:0] cmd_arg = '0;
    logic        cmd_o, cmd_oe, cmd_od, busy, done, abort;

    cmdseq_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .clk_en     (clk_en),
        .init_req   (init_req),
        .boot_force (boot_force),
        .ceata_mode (ceata_mode),
        .host_resp  (host_resp),
        .od_mode    (od_mode),
        .cmd_trig   (cmd_trig),
        .cmd_arg    (cmd_arg),
        .cmd_o      (cmd_o),
        .cmd_oe     (cmd_oe),
        .cmd_od     (cmd_od),
        .busy       (busy),
        .done       (done),
        .abort      (abort)
    );

    always #4 clk = ~clk;

    int div = 0;
    always @(negedge clk) begin
        div    = (div + 1) % 4;
        clk_en = (div == 0);
    end

    int run_ticks = 0;
    bit last_edge_tick = 1'b0;
    always @(posedge clk) begin
        last_edge_tick = clk_en;
        if (clk_en) run_ticks++;
    end

    task automatic push(input int kind, input bit oe, input bit lvl, input bit od,
                        input int ticks, input string req);
        item_t it;
        it.kind = kind; it.oe = oe; it.lvl = lvl; it.od = od;
        it.ticks = ticks; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic emit(input int kind, input bit oe, input bit lvl, input bit od, input int ticks);
        item_t e;
        n_tests++;
        if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL %s unexpected item: actual kind=%0d oe=%0b lvl=%0b od=%0b ticks=%0d expected none",
                     cur_req, kind, oe, lvl, od, ticks);
            return;
        end
        e = exp_q.pop_front();
        if (e.kind != kind || e.oe != oe || e.lvl != lvl || e.od != od ||
            (e.ticks >= 0 && e.ticks != ticks)) begin
            n_fail++;
            $display("FAIL %s item: actual kind=%0d oe=%0b lvl=%0b od=%0b ticks=%0d expected kind=%0d oe=%0b lvl=%0b od=%0b ticks=%0d",
                     e.req, kind, oe, lvl, od, ticks, e.kind, e.oe, e.lvl, e.od, e.ticks);
        end
    endtask

    // scoreboard monitor
    logic [2:0] run_st = 3'b010;
    bit         done_prev = 1'b0;
    bit         abort_prev = 1'b0;
    int         busy_err = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if ({cmd_oe, cmd_o, cmd_od} != run_st) begin
                n_tests++;
                if (!last_edge_tick) begin
                    n_fail++;
                    $display("FAIL R7 line change off tick: actual clk_en=0 expected clk_en=1");
                end
                if (run_st[2] || run_st[0])
                    emit(K_SEG, run_st[2], run_st[1], run_st[0], run_ticks);
                run_st    = {cmd_oe, cmd_o, cmd_od};
                run_ticks = 0;
            end
            if (done) begin
                if (done_prev) begin
                    n_fail++;
                    $display("FAIL R12 done width: actual 2+ cycles expected 1");
                end
                emit(K_DONE, 0, 0, 0, 0);
            end
            if (abort) begin
                if (abort_prev) begin
                    n_fail++;
                    $display("FAIL R12 abort width: actual 2+ cycles expected 1");
                end
                emit(K_ABORT, 0, 0, 0, 0);
            end
            done_prev  = done;
            abort_prev = abort;
            if (busy != (cmd_oe | cmd_od)) busy_err++;
        end
    end

    task automatic pulse_trig(input logic [31:0] a);
        @(negedge clk);
        cmd_arg  = a;
        cmd_trig = 1'b1;
        @(negedge clk);
        cmd_trig = 1'b0;
    endtask

    task automatic wait_drain();
        do @(negedge clk); while (exp_q.size() != 0 || busy);
        repeat (8) @(negedge clk);
    endtask

    task automatic check_idle(input string req);
        @(negedge clk);
        n_tests++;
        if (busy || cmd_oe || cmd_od || !cmd_o || done || abort) begin
            n_fail++;
            $display("FAIL %s idle: actual busy=%0b oe=%0b od=%0b o=%0b done=%0b abort=%0b expected 0 0 0 1 0 0",
                     req, busy, cmd_oe, cmd_od, cmd_o, done, abort);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R9 watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        check_idle("R8");

        // R1 init stream; R9 strobes during it are ignored
        cur_req = "R1";
        push(K_SEG, 1, 1, 0, 80, "R1");
        push(K_DONE, 0, 0, 0, 0, "R1");
        init_req = 1'b1;
        repeat (60) @(negedge clk);
        cur_req = "R9";
        ceata_mode = 1'b1; host_resp = 1'b1;
        pulse_trig(32'h0);
        ceata_mode = 1'b0; host_resp = 1'b0;
        wait_drain();
        // R2 held request does not restart
        cur_req = "R2";
        repeat (200) @(negedge clk);
        check_idle("R2");
        init_req = 1'b0;
        repeat (8) @(negedge clk);

        // R3 boot hold, R4 release with abort, R9 strobe while held
        cur_req = "R3";
        push(K_SEG, 1, 0, 0, -1, "R3");
        push(K_ABORT, 0, 0, 0, 0, "R4");
        boot_force = 1'b1;
        pulse_trig(32'h1234_5678);
        repeat (100) @(negedge clk);
        n_tests++;
        if (!busy || !cmd_oe || cmd_o) begin
            n_fail++;
            $display("FAIL R3 hold: actual busy=%0b oe=%0b o=%0b expected 1 1 0", busy, cmd_oe, cmd_o);
        end
        cur_req = "R9";
        pulse_trig(32'h0);
        repeat (20) @(negedge clk);
        boot_force = 1'b0;
        cur_req = "R4";
        wait_drain();
        check_idle("R4");

        // R5 token, push-pull
        cur_req = "R5";
        ceata_mode = 1'b1; host_resp = 1'b1;
        push(K_SEG, 1, 0, 0, 47, "R5");
        push(K_SEG, 1, 1, 0, 1, "R5");
        push(K_DONE, 0, 0, 0, 0, "R5");
        pulse_trig(32'h0);
        wait_drain();

        // R6 token, open drain
        cur_req = "R6";
        od_mode = 1'b1;
        push(K_SEG, 1, 0, 1, 47, "R6");
        push(K_SEG, 0, 1, 1, 1, "R6");
        push(K_DONE, 0, 0, 0, 0, "R6");
        pulse_trig(32'h0);
        wait_drain();
        od_mode = 1'b0;

        // R10 non-qualifying strobes
        cur_req = "R10";
        pulse_trig(32'h0000_0001);
        repeat (40) @(negedge clk);
        check_idle("R10");
        host_resp = 1'b0;
        pulse_trig(32'h0);
        repeat (40) @(negedge clk);
        check_idle("R10");
        ceata_mode = 1'b0; host_resp = 1'b1;
        pulse_trig(32'h0);
        repeat (40) @(negedge clk);
        check_idle("R10");
        host_resp = 1'b0;

        // R11 trigger wins over init request
        cur_req = "R11";
        push(K_SEG, 1, 0, 0, -1, "R11");
        push(K_ABORT, 0, 0, 0, 0, "R11");
        push(K_SEG, 1, 1, 0, 80, "R11");
        push(K_DONE, 0, 0, 0, 0, "R11");
        boot_force = 1'b1;
        @(negedge clk);
        cmd_arg  = 32'h0;
        cmd_trig = 1'b1;
        @(negedge clk);
        cmd_trig = 1'b0;
        init_req = 1'b1;
        repeat (60) @(negedge clk);
        boot_force = 1'b0;
        wait_drain();
        init_req = 1'b0;
        check_idle("R11");

        n_tests++;
        if (busy_err != 0) begin
            n_fail++;
            $display("FAIL R9 busy tracking: actual %0d mismatching cycles expected 0", busy_err);
        end
        n_tests++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9 scoreboard: actual %0d items left expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule